// File: doc/BRIEF.md
# Selective 2x Luma Interpolator

This block doubles the horizontal luma rate of a pixel stream on a per-pixel-class basis. Each accepted input pixel carries Y, V and U samples, a class flag (1 = video pixel, 0 = graphics pixel), an end-of-line marker and a set of display-timing side signals: a register-address byte, horizontal active, vertical active, composite blank and register-load enable. When doubling is in force, every input pixel leaves as two output beats. The first beat holds the original luma. The second beat holds either the rounded midpoint between this pixel's luma and the next pixel's luma, or a repeat of the original luma. Chroma and side signals stay attached to their pixel on both beats.

Whether a pixel is blended is decided by a master enable and two class-enable bits in a control word. Bit 12 enables video-class pixels and bit 11 enables graphics-class pixels. The decision is taken once, when the pixel is accepted. If the master enable is off, or both class bits are clear, the block is a bypass: it emits one beat per pixel. Every pixel is held for one pixel slot. Its output waits until the following pixel of the same line is offered, or until the pixel is marked as the end of its line. This keeps luma, chroma and timing signals aligned.

Both ends are valid/ready streams. A beat transfers on a clock edge where valid and ready are both high. The upstream source must keep `in_valid` and all `in_*` fields stable until `in_ready` is seen. While `out_valid` is high and `out_ready` is low, the block keeps every `out_*` field stable. The block accepts a new pixel only in the cycle in which the last beat of the held pixel is taken, or when nothing is held.

Top module: `yi_luma_doubler`

## Requirements
- R1: A pixel is blended when `master_en`=1 and either (`in_vid`=1 and `ctrl_word[12]`=1) or (`in_vid`=0 and `ctrl_word[11]`=1). All other bits of `ctrl_word` have no effect.
- R2: When `master_en`=0, or `ctrl_word[12]` and `ctrl_word[11]` are both 0, each pixel produces exactly one output beat. That beat has `out_ins`=0 and the pixel's own Y.
- R3: When `master_en`=1 and at least one of bits 12 or 11 is set, each pixel produces two beats. The first beat has `out_ins`=0 and the pixel's own Y. The second beat has `out_ins`=1.
- R4: For a blended pixel that is not the last pixel of its line, the second beat's Y is (Y[n] + Y[n+1] + 1) >> 1, where Y[n+1] is the next pixel in the stream.
- R5: For a pixel that is doubled but not blended, the second beat repeats Y[n].
- R6: For a pixel accepted with `in_eol`=1, the second beat, when present, repeats Y[n]. `out_last` is 1 on the pixel's final beat and 0 on every other beat.
- R7: `out_v`, `out_u`, `out_regaddr`, `out_hact`, `out_vact`, `out_blank` and `out_regld` on every beat of a pixel equal that pixel's input values.
- R8: While the held pixel has `in_eol`=0 and no next pixel is offered, `out_valid` stays 0.
- R9: The class decision uses `master_en` and `ctrl_word` as sampled when the pixel is accepted. Later changes do not alter that pixel's beats.
- R10: While `out_valid`=1 and `out_ready`=0, the next cycle keeps `out_valid`=1 and all output fields unchanged. An input is accepted while a pixel is held only together with the final beat of that pixel.
- R11: After reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | Master interpolation enable |
| ctrl_word | input | 16 | Control word; bit 12 = video enable, bit 11 = graphics enable |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_y | input | 8 | Luma sample |
| in_v | input | 8 | V chroma sample |
| in_u | input | 8 | U chroma sample |
| in_vid | input | 1 | Class flag: 1 video, 0 graphics |
| in_eol | input | 1 | Last pixel of the line |
| in_regaddr | input | 8 | Register-address byte |
| in_hact | input | 1 | Horizontal active |
| in_vact | input | 1 | Vertical active |
| in_blank | input | 1 | Composite blank |
| in_regld | input | 1 | Register-load enable |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_y | output | 8 | Output luma |
| out_v | output | 8 | Aligned V |
| out_u | output | 8 | Aligned U |
| out_ins | output | 1 | 1 on the inserted (second) beat |
| out_last | output | 1 | Final beat of a line |
| out_regaddr | output | 8 | Aligned register-address byte |
| out_hact | output | 1 | Aligned horizontal active |
| out_vact | output | 1 | Aligned vertical active |
| out_blank | output | 1 | Aligned composite blank |
| out_regld | output | 1 | Aligned register-load enable |

## Verification
The bench sweeps all eight combinations of master enable and the two class bits. Each sweep runs over lines in which video and graphics pixels alternate irregularly, so a swapped class bit, or a decode that ignores the flag, changes specific beats. Luma values include 255/255 pairs and odd sums, which separate a correct round-up midpoint from truncation or overflow. Some runs redraw the control word and master enable for every pixel, changing them while the previous pixel is still held; this exposes a decode that is not latched at acceptance. Idle gaps after non-final pixels and three patterns of downstream ready exercise the wait for the next sample and the stability of the output during stalls.

// File: rtl/yi_pkg.sv
`timescale 1ns/1ps
package yi_pkg;
  // class decision captured with each accepted pixel
  typedef struct packed {
    logic interp;  // second beat is a blend with the next sample
    logic dbl;     // pixel occupies two output beats
  } yi_class_t;

  // single-bit display timing companions
  typedef struct packed {
    logic hact;
    logic vact;
    logic blank;
    logic regld;
  } yi_side_t;
endpackage

// File: rtl/yi_class_decode.sv
`timescale 1ns/1ps
module yi_class_decode
  import yi_pkg::*;
#(
  parameter int CTRLW   = 16,
  parameter int VID_BIT = 12,
  parameter int GFX_BIT = 11
) (
  input  logic             master_en,
  input  logic [CTRLW-1:0] ctrl_word,
  input  logic             vid,
  output yi_class_t        cls
);
  logic vid_en, gfx_en;

  assign vid_en = ctrl_word[VID_BIT];
  assign gfx_en = ctrl_word[GFX_BIT];

  always_comb begin
    cls.dbl    = master_en & (vid_en | gfx_en);
    cls.interp = master_en & (vid ? vid_en : gfx_en);
  end
endmodule

// File: rtl/yi_midpoint.sv
`timescale 1ns/1ps
module yi_midpoint #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] mid
);
  logic [W:0] sum;

  // one extra bit keeps the carry; +1 rounds halves upward
  assign sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, 1'b1};
  assign mid = sum[W:1];
endmodule

// File: rtl/yi_luma_doubler.sv
`timescale 1ns/1ps
module yi_luma_doubler
  import yi_pkg::*;
#(
  parameter int YW      = 8,
  parameter int CW      = 8,
  parameter int AW      = 8,
  parameter int CTRLW   = 16,
  parameter int VID_BIT = 12,
  parameter int GFX_BIT = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic [CTRLW-1:0] ctrl_word,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [YW-1:0]    in_y,
  input  logic [CW-1:0]    in_v,
  input  logic [CW-1:0]    in_u,
  input  logic             in_vid,
  input  logic             in_eol,
  input  logic [AW-1:0]    in_regaddr,
  input  logic             in_hact,
  input  logic             in_vact,
  input  logic             in_blank,
  input  logic             in_regld,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [YW-1:0]    out_y,
  output logic [CW-1:0]    out_v,
  output logic [CW-1:0]    out_u,
  output logic             out_ins,
  output logic             out_last,
  output logic [AW-1:0]    out_regaddr,
  output logic             out_hact,
  output logic             out_vact,
  output logic             out_blank,
  output logic             out_regld
);
  // held pixel (one-slot alignment stage)
  logic            hold_vld;
  logic [YW-1:0]   h_y;
  logic [CW-1:0]   h_v, h_u;
  logic [AW-1:0]   h_addr;
  yi_side_t        h_side;
  yi_class_t       h_cls;
  logic            h_eol;
  logic            ins_q;      // 1 while the second beat is pending

  yi_class_t       new_cls;
  logic [YW-1:0]   blend_y;
  logic            out_fire, in_fire, finish;

  yi_class_decode #(
    .CTRLW  (CTRLW),
    .VID_BIT(VID_BIT),
    .GFX_BIT(GFX_BIT)
  ) u_decode (
    .master_en(master_en),
    .ctrl_word(ctrl_word),
    .vid      (in_vid),
    .cls      (new_cls)
  );

  yi_midpoint #(.W(YW)) u_mid (
    .a  (h_y),
    .b  (in_y),
    .mid(blend_y)
  );

  // beat currently presented ends the held pixel
  assign finish    = !h_cls.dbl || ins_q;
  // a non-final pixel needs its successor before it may leave
  assign out_valid = hold_vld && (h_eol || in_valid);
  assign out_fire  = out_valid && out_ready;
  assign in_ready  = !hold_vld || (out_fire && finish);
  assign in_fire   = in_valid && in_ready;

  always_comb begin
    if (ins_q && h_cls.interp && !h_eol) out_y = blend_y;
    else                                  out_y = h_y;
  end

  assign out_ins     = ins_q;
  assign out_last    = out_valid && h_eol && finish;
  assign out_v       = h_v;
  assign out_u       = h_u;
  assign out_regaddr = h_addr;
  assign out_hact    = h_side.hact;
  assign out_vact    = h_side.vact;
  assign out_blank   = h_side.blank;
  assign out_regld   = h_side.regld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      ins_q    <= 1'b0;
      h_y      <= '0;
      h_v      <= '0;
      h_u      <= '0;
      h_addr   <= '0;
      h_side   <= '0;
      h_cls    <= '0;
      h_eol    <= 1'b0;
    end else begin
      if (out_fire) ins_q <= !finish;
      if (in_fire) begin
        hold_vld <= 1'b1;
        h_y      <= in_y;
        h_v      <= in_v;
        h_u      <= in_u;
        h_addr   <= in_regaddr;
        h_side   <= '{hact: in_hact, vact: in_vact, blank: in_blank, regld: in_regld};
        h_cls    <= new_cls;
        h_eol    <= in_eol;
      end else if (out_fire && finish) begin
        hold_vld <= 1'b0;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_y) && $stable(out_ins) && $stable(out_v)) // R10
    else $error("stalled beat changed");

  AST_ACCEPT_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && hold_vld |-> out_valid && out_ready && (out_ins || !h_cls.dbl)) // R10
    else $error("input taken before held pixel finished");

  AST_BYPASS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !h_cls.dbl |-> !out_ins) // R2
    else $error("inserted beat in bypass");

  AST_SECOND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_ins && h_cls.dbl |=> out_valid && out_ins) // R3
    else $error("second beat missing");

  AST_LINE_END_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_ins) // R6
    else $error("phase not cleared after line end");

  AST_WAIT_FOR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_vld && !h_eol && !in_valid |-> !out_valid) // R8
    else $error("non-final pixel left without successor");
endmodule

// File: tb/yi_luma_doubler_bench.sv
`timescale 1ns/1ps
module yi_luma_doubler_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, master_en, in_valid, in_ready, in_vid, in_eol;
  logic [15:0] ctrl_word;
  logic [7:0]  in_y, in_v, in_u, in_regaddr;
  logic        in_hact, in_vact, in_blank, in_regld;
  logic        out_valid, out_ready, out_ins, out_last;
  logic [7:0]  out_y, out_v, out_u, out_regaddr;
  logic        out_hact, out_vact, out_blank, out_regld;

  yi_luma_doubler u_yi_luma_doubler (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .ctrl_word(ctrl_word),
    .in_valid(in_valid), .in_ready(in_ready), .in_y(in_y), .in_v(in_v), .in_u(in_u),
    .in_vid(in_vid), .in_eol(in_eol), .in_regaddr(in_regaddr), .in_hact(in_hact),
    .in_vact(in_vact), .in_blank(in_blank), .in_regld(in_regld),
    .out_valid(out_valid), .out_ready(out_ready), .out_y(out_y), .out_v(out_v),
    .out_u(out_u), .out_ins(out_ins), .out_last(out_last), .out_regaddr(out_regaddr),
    .out_hact(out_hact), .out_vact(out_vact), .out_blank(out_blank), .out_regld(out_regld)
  );

  int total = 0, fails = 0, cyc = 0;

  // stimulus
  int       py[16], pv[16], pu[16], pad[16], pside[16];
  bit       pvid[16], peol[16], pme[16];
  bit [15:0] pct[16];
  int       np;
  // expected beats
  int       ey[32], echr[32], eins[32], elast[32];
  string    etag[32];
  int       nexp;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic build(int n, int seed, bit me, bit cv, bit cg, bit vary, int llen);
    np = n;
    nexp = 0;
    for (int i = 0; i < n; i++) begin
      bit m, v, g, dbl, itp;
      string pre;
      py[i] = (i * 97 + seed * 53 + 11) % 256;
      if (i % 5 == 2 || i % 5 == 3) py[i] = 255;
      if (i % 7 == 4 && seed % 2 == 1) py[i] = 0;
      pv[i] = (i * 29 + seed * 7) % 256;
      pu[i] = (i * 41 + seed * 3 + 100) % 256;
      pad[i] = (i * 13 + seed) % 256;
      pside[i] = (i * 5 + seed) % 16;
      pvid[i] = ((i * i + seed + i) % 3) == 1;
      peol[i] = (i % llen == llen - 1) || (i == n - 1);
      if (vary) begin
        m = ((i * 7 + seed) % 4) != 0;
        v = ((i * 5 + seed) % 3) == 0;
        g = ((i + seed) % 2) == 1;
      end else begin
        m = me; v = cv; g = cg;
      end
      pme[i] = m;
      pct[i] = ((16'(i) * 16'd4099) & 16'h67FF) | (16'(v) << 12) | (16'(g) << 11);
    end
    for (int i = 0; i < n; i++) begin
      bit v, g, dbl, itp;
      string pre;
      int chr;
      v = pct[i][12]; g = pct[i][11];
      dbl = pme[i] && (v || g);
      itp = pme[i] && (pvid[i] ? v : g);
      pre = vary ? "R9 " : "";
      chr = (pv[i] << 20) | (pu[i] << 12) | (pad[i] << 4) | pside[i];
      if (!dbl) begin
        ey[nexp] = py[i]; echr[nexp] = chr; eins[nexp] = 0; elast[nexp] = peol[i];
        etag[nexp] = {pre, "R1 R2 bypass"}; nexp++;
      end else begin
        ey[nexp] = py[i]; echr[nexp] = chr; eins[nexp] = 0; elast[nexp] = 0;
        etag[nexp] = {pre, "R3 first beat"}; nexp++;
        echr[nexp] = chr; eins[nexp] = 1; elast[nexp] = peol[i];
        if (itp && !peol[i]) begin
          ey[nexp] = (py[i] + py[i+1] + 1) >> 1; etag[nexp] = {pre, "R1 R4 midpoint"};
        end else if (peol[i]) begin
          ey[nexp] = py[i]; etag[nexp] = {pre, "R6 line-end repeat"};
        end else begin
          ey[nexp] = py[i]; etag[nexp] = {pre, "R1 R5 repeat"};
        end
        nexp++;
      end
    end
  endtask

  task automatic drive_idle();
    in_valid = 0; in_y = 0; in_v = 0; in_u = 0; in_vid = 0; in_eol = 0;
    in_regaddr = 0; in_hact = 0; in_vact = 0; in_blank = 0; in_regld = 0;
    master_en = 0; ctrl_word = 0;
  endtask

  task automatic run(int rmode, bit gaps);
    int ii = 0, io = 0, gap = 0, lim;
    bit pstall = 0;
    int py_s = 0, pins_s = 0;
    lim = cyc + 2000;
    while (io < nexp) begin
      @(negedge clk);
      cyc++;
      if (cyc > lim) begin
        fails++; total++;
        $display("FAIL watchdog: got %0d expected %0d beats", io, nexp);
        break;
      end
      if (gap > 0 || ii >= np) begin
        drive_idle();
        if (gap > 0) gap--;
      end else begin
        in_valid = 1; in_y = py[ii][7:0]; in_v = pv[ii][7:0]; in_u = pu[ii][7:0];
        in_vid = pvid[ii]; in_eol = peol[ii]; in_regaddr = pad[ii][7:0];
        {in_hact, in_vact, in_blank, in_regld} = pside[ii][3:0];
        master_en = pme[ii]; ctrl_word = pct[ii];
      end
      case (rmode)
        0: out_ready = 1;
        1: out_ready = cyc[0];
        default: out_ready = ((cyc * 13 + 5) % 7) > 2;
      endcase
      #1;
      if (!in_valid && ii > 0 && ii < np + 1 && !peol[ii-1] && io < nexp)
        chk("R8 wait for successor", int'(out_valid), 0);
      if (pstall) begin
        chk("R10 stall valid", int'(out_valid), 1);
        chk("R10 stall data", int'({out_y, out_ins}), int'({py_s[7:0], pins_s[0]}));
      end
      pstall = out_valid && !out_ready;
      py_s = out_y; pins_s = out_ins;
      if (out_valid && out_ready) begin
        chk(etag[io], int'(out_y), ey[io]);
        chk("R7 aligned chroma/side",
            int'({out_v, out_u, out_regaddr, out_hact, out_vact, out_blank, out_regld}), echr[io]);
        chk(eins[io] ? "R3 inserted flag" : "R2 R3 first flag", int'(out_ins), eins[io]);
        chk("R6 line marker", int'(out_last), elast[io]);
        io++;
      end
      if (in_valid && in_ready) begin
        ii++;
        if (gaps && ii % 4 == 1 && ii < np) gap = 2;
      end
    end
    @(negedge clk);
    drive_idle();
  endtask

  initial begin
    drive_idle();
    out_ready = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R11 reset valid", int'(out_valid), 0);
    chk("R11 reset ready", int'(in_ready), 1);
    rst_n = 1;
    for (int c = 0; c < 8; c++) begin
      build(15, c, c[2], c[1], c[0], 0, 5);
      run(c % 3, c[0]);
    end
    for (int s = 0; s < 3; s++) begin
      build(16, 20 + s, 0, 0, 0, 1, 6);
      run(s, s[0]);
    end
    build(16, 9, 1, 1, 1, 0, 16);
    run(2, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #500000;
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule